// File: doc/BRIEF.md
# Microstepped 16-bit Processor Core

This core runs a short instruction set by breaking every instruction into single register transfers, one per clock. A fixed fetch series copies the program counter into the memory address register, pushes it through a separate incrementer and back, reads the addressed word into the memory data register, moves it into the instruction register, and then decodes the opcode. An execute series for the decoded opcode follows, and control returns to the start of fetch.

The datapath holds a program counter, an incrementer register, memory address and data registers, an instruction register, two general registers A and B, two ALU operand latches, an ALU result register and a zero flag. Instruction words are 16 bits wide. Bits 15:8 hold the opcode and bits 7:0 hold a signed operand. The memory port reads combinationally: the word at `mem_addr` appears on `mem_rdata` in the same cycle. The core never writes memory. A halt instruction freezes the core until reset. The register outputs give the surrounding system and the bench a view of the architectural state.

Top module: `useq_core`

## Requirements
- R1: While reset is asserted, PC, A, B and the zero flag read 0 and `halted` is 0. The first memory read after reset uses address 0x0000.
- R2: Each instruction is fetched with exactly one memory read (`mem_re` high for one cycle), at the fetch step that follows MAR, INC and PC, and the address is the PC value the instruction started with.
- R3: When no branch is taken, PC advances by one per instruction, and always through the incrementer register.
- R4: Opcode 0x01 loads A and opcode 0x02 loads B with the 8-bit operand sign-extended to 16 bits (0x80 gives 0xFF80).
- R5: Opcode 0x10 sets A to (A + B) mod 2^16 through four steps: operand X from A, operand Y from B, result, write-back to A. B is unchanged.
- R6: Opcode 0x11 sets A to the bitwise AND of A and B through the same four steps.
- R7: The zero flag is 1 exactly when the last ALU result was 0x0000. It changes only at the ALU result step, and loads, branches and undefined opcodes leave it alone.
- R8: Opcode 0x20 with the zero flag at 1 loads PC with the sign-extended operand. With the flag at 0, PC keeps its incremented value.
- R9: Opcode 0xFF raises `halted`. From then on there are no memory reads and PC, A, B and the flag stay fixed until reset.
- R10: Any other opcode is fetched and skipped: only PC changes.
- R11: Clock cycles per instruction: loads 7, ALU operations 10, branch 7, undefined opcodes 6. For a halt, `halted` rises 6 cycles after its fetch begins.
- R12: Synchronous reset takes priority over every micro-step. One clocked reset at any point puts the core back in the R1 state and restarts fetch at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory word address (the MAR) |
| mem_rdata | input | 16 | Word read at `mem_addr`, valid in the same cycle |
| mem_wdata | output | 16 | Write data (the MDR) |
| mem_we | output | 1 | Write enable, held 0 |
| mem_re | output | 1 | Read strobe, high in the memory-read fetch step |
| halted | output | 1 | Core has run a halt instruction |
| dbg_pc | output | 16 | Program counter |
| dbg_a | output | 16 | Register A |
| dbg_b | output | 16 | Register B |
| dbg_z | output | 1 | Zero flag |

## Verification
Two things can land on the same clock edge: reset and a micro-step that is in flight. Examples are an ALU write-back, the memory-read step, or the halt state itself. The bench raises reset after a random number of cycles inside a running program, and also while the core is halted. After one clocked reset cycle it requires the R1 state at the ports. It then requires that a full rerun of the same program matches the bench's instruction-level model in final registers, flag, read count and cycle count.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 8;
  localparam int unsigned OPD_W  = WORD_W - OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_LDA  = 8'h01,
    OPC_LDB  = 8'h02,
    OPC_ADD  = 8'h10,
    OPC_AND  = 8'h11,
    OPC_BZ   = 8'h20,
    OPC_HALT = 8'hFF
  } opc_e;

  typedef enum logic [3:0] {
    ST_MAR, ST_INC, ST_PC, ST_MDR, ST_IR, ST_DEC,
    ST_LDA, ST_LDB, ST_AX, ST_AY, ST_AR, ST_WA, ST_BZ, ST_HALT
  } step_e;

  typedef enum logic {ALU_ADD, ALU_AND} alu_op_e;

  function automatic logic [WORD_W-1:0] sext_opd(input logic [OPD_W-1:0] v);
    return {{(WORD_W-OPD_W){v[OPD_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] incr(input logic [WORD_W-1:0] v);
    return v + WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] alu_fn(input alu_op_e op,
                                               input logic [WORD_W-1:0] x,
                                               input logic [WORD_W-1:0] y);
    return (op == ALU_AND) ? (x & y) : (x + y);
  endfunction
endpackage

// File: rtl/useq_alu.sv
`timescale 1ns/1ps
module useq_alu
  import useq_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  output logic [WORD_W-1:0] res,
  output logic              zero
);
  always_comb begin
    res  = alu_fn(op, x, y);
    zero = (res == '0);
  end
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output step_e            step
);
  step_e step_nx;
  logic  opc_known;

  always_comb begin
    opc_known = (opcode == OPC_LDA) || (opcode == OPC_LDB) || (opcode == OPC_ADD) ||
                (opcode == OPC_AND) || (opcode == OPC_BZ)  || (opcode == OPC_HALT);
    case (step)
      ST_MAR:  step_nx = ST_INC;
      ST_INC:  step_nx = ST_PC;
      ST_PC:   step_nx = ST_MDR;
      ST_MDR:  step_nx = ST_IR;
      ST_IR:   step_nx = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OPC_LDA:          step_nx = ST_LDA;
          OPC_LDB:          step_nx = ST_LDB;
          OPC_ADD, OPC_AND: step_nx = ST_AX;
          OPC_BZ:           step_nx = ST_BZ;
          OPC_HALT:         step_nx = ST_HALT;
          default:          step_nx = ST_MAR;
        endcase
      end
      ST_AX:   step_nx = ST_AY;
      ST_AY:   step_nx = ST_AR;
      ST_AR:   step_nx = ST_WA;
      ST_HALT: step_nx = ST_HALT;
      default: step_nx = ST_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_MAR;
    else     step <= step_nx;
  end

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (step == ST_MAR) |=> (step == ST_INC));
  // R5
  alu_order_chk: assert property (@(posedge clk) disable iff (rst)
    (step == ST_AY) |=> (step == ST_AR));
  // R10
  undef_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DEC && !opc_known) |=> (step == ST_MAR));
endmodule

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core
  import useq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        halted,
  output logic [15:0] dbg_pc,
  output logic [15:0] dbg_a,
  output logic [15:0] dbg_b,
  output logic        dbg_z
);
  step_e step;
  logic [WORD_W-1:0] pc_q, inc_q, mar_q, mdr_q, ir_q;
  logic [WORD_W-1:0] a_q, b_q, alux_q, aluy_q, alur_q;
  logic              z_q;
  logic [WORD_W-1:0] alu_res;
  logic              alu_zero;
  alu_op_e           alu_op;

  // named events for the checks
  logic pc_from_inc, br_take, alu_step;
  assign pc_from_inc = (step == ST_PC);
  assign br_take     = (step == ST_BZ) && z_q;
  assign alu_step    = (step == ST_AR);

  assign alu_op = (ir_q[WORD_W-1 -: OPC_W] == OPC_AND) ? ALU_AND : ALU_ADD;

  useq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[WORD_W-1 -: OPC_W]),
    .step   (step)
  );

  useq_alu u_alu (
    .op   (alu_op),
    .x    (alux_q),
    .y    (aluy_q),
    .res  (alu_res),
    .zero (alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; inc_q <= '0; mar_q <= '0; mdr_q <= '0; ir_q <= '0;
      a_q <= '0; b_q <= '0; alux_q <= '0; aluy_q <= '0; alur_q <= '0;
      z_q <= 1'b0;
    end else begin
      case (step)
        ST_MAR: mar_q  <= pc_q;
        ST_INC: inc_q  <= incr(pc_q);
        ST_PC:  pc_q   <= inc_q;
        ST_MDR: mdr_q  <= mem_rdata;
        ST_IR:  ir_q   <= mdr_q;
        ST_LDA: a_q    <= sext_opd(ir_q[OPD_W-1:0]);
        ST_LDB: b_q    <= sext_opd(ir_q[OPD_W-1:0]);
        ST_AX:  alux_q <= a_q;
        ST_AY:  aluy_q <= b_q;
        ST_AR: begin
          alur_q <= alu_res;
          z_q    <= alu_zero;
        end
        ST_WA:  a_q    <= alur_q;
        ST_BZ:  if (z_q) pc_q <= sext_opd(ir_q[OPD_W-1:0]);
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = 1'b0;
  assign mem_re    = (step == ST_MDR);
  assign halted    = (step == ST_HALT);
  assign dbg_pc    = pc_q;
  assign dbg_a     = a_q;
  assign dbg_b     = b_q;
  assign dbg_z     = z_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0 && a_q == '0 && !z_q && !halted));
  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr == pc_q - WORD_W'(1)));
  // R3
  pc_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_q) |-> ($past(pc_from_inc) || $past(br_take)));
  // R7
  z_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(z_q) |-> $past(alu_step));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_q) && $stable(a_q)));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_re);
endmodule

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, mem_re, halted, dbg_z;
  logic [15:0] dbg_pc, dbg_a, dbg_b;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  always #2.5 clk = ~clk;

  useq_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_a(dbg_a), .dbg_b(dbg_b), .dbg_z(dbg_z)
  );

  int n_chk = 0;
  int n_fail = 0;

  // expected results from the instruction-level model
  logic [15:0] e_pc, e_a, e_b;
  logic        e_z;
  int          e_cyc, e_rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [7:0] v);
    return v[7] ? (16'hFF00 | 16'(v)) : 16'(v);
  endfunction

  function automatic logic [15:0] ins(input logic [7:0] op, input logic [7:0] opd);
    return {op, opd};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hFF00;
  endtask

  // instruction-level model: cycle costs and effects taken from the requirements
  task automatic ref_run();
    logic [15:0] w;
    logic        stop;
    e_pc = 0; e_a = 0; e_b = 0; e_z = 0; e_cyc = 0; e_rd = 0; stop = 0;
    for (int s = 0; s < 400 && !stop; s++) begin
      w = mem[e_pc[7:0]];
      e_pc = e_pc + 16'd1;
      e_rd++;
      case (w[15:8])
        8'h01: begin e_a = sx(w[7:0]); e_cyc += 7; end
        8'h02: begin e_b = sx(w[7:0]); e_cyc += 7; end
        8'h10: begin e_a = e_a + e_b; e_z = (e_a == 0); e_cyc += 10; end
        8'h11: begin e_a = e_a & e_b; e_z = (e_a == 0); e_cyc += 10; end
        8'h20: begin if (e_z) e_pc = sx(w[7:0]); e_cyc += 7; end
        8'hFF: begin e_cyc += 6; stop = 1; end
        default: e_cyc += 6;
      endcase
    end
  endtask

  task automatic run_and_check(input string tag);
    int cyc, rd, quiet;
    logic [15:0] first_addr, pc_h, a_h;
    logic got_first;
    ref_run();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0; rd = 0; got_first = 0; first_addr = 16'hFFFF;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (mem_re) begin
        rd++;
        if (!got_first) begin first_addr = mem_addr; got_first = 1; end
      end
    end
    check({"R1 first fetch address ", tag}, 32'(first_addr), 32'h0);
    check({"R11 cycles to halt ", tag}, cyc, e_cyc);
    check({"R2 reads per program ", tag}, rd, e_rd);
    check({"R3 final pc ", tag}, 32'(dbg_pc), 32'(e_pc));
    check({tag, " reg A"}, 32'(dbg_a), 32'(e_a));
    check({tag, " reg B"}, 32'(dbg_b), 32'(e_b));
    check({"R7 zero flag ", tag}, 32'(dbg_z), 32'(e_z));
    pc_h = dbg_pc; a_h = dbg_a; quiet = 0;
    repeat (8) begin
      @(negedge clk);
      if (mem_re) quiet++;
    end
    check({"R9 reads after halt ", tag}, quiet, 0);
    check({"R9 frozen state ", tag}, {dbg_pc, dbg_a}, {pc_h, a_h});
    check({"R9 still halted ", tag}, 32'(halted), 32'h1);
  endtask

  task automatic reset_mid(input int k, input string tag);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (k) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({"R12 pc after reset ", tag}, 32'(dbg_pc), 0);
    check({"R12 regs after reset ", tag}, {dbg_a, dbg_b, 15'd0, dbg_z}, 0);
    check({"R12 halted after reset ", tag}, 32'(halted), 0);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc in reset", 32'(dbg_pc), 0);
    check("R1 A,B,Z in reset", {dbg_a, dbg_b, 15'd0, dbg_z}, 0);
    check("R1 halted in reset", 32'(halted), 0);
    check("R1 no read in reset", 32'(mem_re), 0);

    // R5 add program: A=8
    clear_mem();
    mem[0] = ins(8'h01, 8'h05); mem[1] = ins(8'h02, 8'h03);
    mem[2] = ins(8'h10, 8'h00); mem[3] = ins(8'hFF, 8'h00);
    run_and_check("R5 add");
    check("R5 add result is 8", 32'(dbg_a), 32'h8);
    check("R11 add program cycles 30", e_cyc, 30);

    // R4 sign extension, R6 AND to zero, R8 taken branch
    clear_mem();
    mem[0] = ins(8'h01, 8'h80); mem[1] = ins(8'h02, 8'h7F);
    mem[2] = ins(8'h11, 8'h00); mem[3] = ins(8'h20, 8'h05);
    mem[4] = ins(8'h01, 8'h01); mem[5] = ins(8'hFF, 8'h00);
    run_and_check("R6 and+R8 taken");
    check("R4 B sign-extended positive", 32'(dbg_b), 32'h007F);
    check("R8 skipped load leaves A zero", 32'(dbg_a), 0);

    clear_mem();
    mem[0] = ins(8'h01, 8'h80); mem[1] = ins(8'hFF, 8'h00);
    run_and_check("R4 negative load");
    check("R4 0x80 loads 0xFF80", 32'(dbg_a), 32'hFF80);

    // R8 not taken
    clear_mem();
    mem[0] = ins(8'h01, 8'h01); mem[1] = ins(8'h02, 8'h01);
    mem[2] = ins(8'h10, 8'h00); mem[3] = ins(8'h20, 8'h05);
    mem[4] = ins(8'h01, 8'h07); mem[5] = ins(8'hFF, 8'h00);
    run_and_check("R8 not taken");
    check("R8 fall-through load ran", 32'(dbg_a), 32'h7);

    // R10 undefined opcodes, R5 wrap to zero, R7 flag survives later loads
    clear_mem();
    mem[0] = ins(8'h00, 8'h12); mem[1] = ins(8'h37, 8'h00);
    mem[2] = ins(8'h01, 8'hFF); mem[3] = ins(8'h02, 8'h01);
    mem[4] = ins(8'h10, 8'h00); mem[5] = ins(8'hFE, 8'h55);
    mem[6] = ins(8'h01, 8'h04); mem[7] = ins(8'hFF, 8'h00);
    run_and_check("R10 undefined");
    check("R7 flag kept after load", 32'(dbg_z), 1);
    check("R10 A after skips", 32'(dbg_a), 32'h4);

    // R12 reset colliding with running steps and with halt
    clear_mem();
    mem[0] = ins(8'h01, 8'h05); mem[1] = ins(8'h02, 8'h03);
    mem[2] = ins(8'h10, 8'h00); mem[3] = ins(8'hFF, 8'h00);
    for (int t = 0; t < 6; t++) begin
      reset_mid(int'($urandom_range(1, 29)), "mid-run");
      run_and_check("R12 rerun");
    end
    reset_mid(40, "while halted");
    run_and_check("R12 rerun after halt");

    // random programs with forward branches
    for (int p = 0; p < 40; p++) begin
      int len;
      logic [7:0] opd;
      clear_mem();
      len = int'($urandom_range(3, 14));
      for (int i = 0; i < len - 1; i++) begin
        opd = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
        case ($urandom_range(0, 5))
          0: mem[i] = ins(8'h01, opd);
          1: mem[i] = ins(8'h02, opd);
          2: mem[i] = ins(8'h10, 8'h00);
          3: mem[i] = ins(8'h11, 8'h00);
          4: mem[i] = ins(8'h20, 8'($urandom_range(i + 1, len - 1)));
          default: mem[i] = ins(8'h42 + 8'($urandom_range(0, 3)), opd);
        endcase
      end
      mem[len-1] = ins(8'hFF, 8'h00);
      run_and_check("R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule